// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and the first-level cache controller. It decides, in the cycle a request is offered, whether the request may enter the memory system. Loads and instruction fetches go into a read table. Stores and both halves of an atomic read-modify-write go into a write table. Both tables are keyed by line address. Only one request may be in flight for a given line, and the two tables together never hold more than a configured number of requests. An accepted request gets a fresh ID and is passed to the cache in the same cycle, with its type converted to the cache's command code and its access mode folded to user or supervisor.

Completion responses name a line and say which table they belong to. A matching completion frees the entry and reports the request's ID and its miss latency in cycles. When an atomic read completes, the block takes a reservation on that line. When an atomic write completes, it succeeds only if it still holds the reservation for its line, and success clears the reservation. A watchdog is armed by the first insertion and checks every threshold period while anything is pending. If any entry has waited at least the threshold, it raises a sticky deadlock flag. The watchdog disarms itself when it finds the tables empty.

Top module: `req_tracker`

## Requirements
- R1: Types are coded 0 load, 1 fetch, 2 store, 3 atomic read, 4 atomic write. Types 0 and 1 occupy the read table and types 2 to 4 the write table. A completion with `cpl_write`=1 retires only a write-table entry and one with `cpl_write`=0 retires only a read-table entry.
- R2: A request is refused whenever the combined occupancy of both tables has reached MAX_OUT.
- R3: A request is refused while any entry in either table holds the same line (address bits above the low log2(LINE_BYTES) offset bits), whatever the type of that entry.
- R4: A request is refused when its own table has no free entry, even if the other table and the combined cap have room.
- R5: A request is refused with no effect on IDs or tables in any of these cases: its length is zero, its offset plus length exceeds LINE_BYTES, its type is above 4, or its mode is 3. A refused request never raises `iss_valid`.
- R6: IDs start at 0 after reset. The ID shown on `req_id` is the one given to an accepted request, and it advances by one only on acceptance.
- R7: `iss_cmd` is 0 for a load, 1 for a fetch, 2 for a store and 3 for either atomic. Modes are coded 0 user, 1 supervisor, 2 device. `iss_super` is 1 only for mode 1, and `iss_line` is the request's line.
- R8: A matching completion raises `rsp_valid` in the same cycle with the entry's ID and a latency equal to the cycles from acceptance to completion, and it frees the line for a new request.
- R9: A completion with no matching entry raises `cpl_unmatched`, gives no response and changes no state.
- R10: An atomic-read completion reserves its line, replacing any earlier reservation. An atomic-write completion reports `rsp_atomic_ok`=1 and clears the reservation only when the reservation is held on its line; otherwise it reports 0. Other completions leave the reservation alone.
- R11: `deadlock` goes high when a watchdog check finds an entry aged at least THRESH cycles; it stays high until reset.
- R12: The watchdog disarms when a check finds both tables empty, so requests retired in time never raise `deadlock`, however long the later idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_type | input | 3 | Request type code |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Length in bytes |
| req_mode | input | 2 | Access mode code |
| req_ready | output | 1 | Offered request would be accepted |
| req_id | output | ID_W | ID given to an accepted request |
| iss_valid | output | 1 | Request forwarded to cache |
| iss_cmd | output | 2 | Converted command code |
| iss_line | output | ADDR_W-log2(LINE_BYTES) | Line address forwarded |
| iss_off | output | log2(LINE_BYTES) | Byte offset in line |
| iss_len | output | LEN_W | Length forwarded |
| iss_super | output | 1 | Supervisor access |
| cpl_valid | input | 1 | Completion arriving |
| cpl_write | input | 1 | Completion targets write table |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Completed line |
| rsp_valid | output | 1 | Completion matched an entry |
| rsp_id | output | ID_W | ID of the retired request |
| rsp_latency | output | TIME_W | Cycles since acceptance |
| rsp_atomic_ok | output | 1 | Atomic write succeeded |
| cpl_unmatched | output | 1 | Completion matched no entry |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
Requests are offered so that each refusal reason applies alone. The cases are the same line at a different offset and of a different type, a full read table while the write table has room, the combined cap with a free slot left, and malformed length, type or mode. This tells the per-line check, the per-table check and the global check apart. Completions are sent to the wrong table and to absent lines to show that retirement depends on the table, and latencies are measured over different gaps. Atomic pairs are run in several orders: a write with no reservation, a matching pair, a repeated write, a reservation moved to another line, and a plain store in between. The watchdog is tried with a request retired early and then a long idle gap, and with a request left pending past the threshold.

// File: rtl/req_tracker.sv
module req_tracker #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 5,
  parameter int RD_ENT     = 4,
  parameter int WR_ENT     = 4,
  parameter int MAX_OUT    = 6,
  parameter int THRESH     = 64,
  parameter int ID_W       = 8,
  parameter int TIME_W     = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [2:0]                            req_type,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [LEN_W-1:0]                      req_len,
  input  logic [1:0]                            req_mode,
  output logic                                  req_ready,
  output logic [ID_W-1:0]                       req_id,
  output logic                                  iss_valid,
  output logic [1:0]                            iss_cmd,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  iss_line,
  output logic [$clog2(LINE_BYTES)-1:0]         iss_off,
  output logic [LEN_W-1:0]                      iss_len,
  output logic                                  iss_super,
  input  logic                                  cpl_valid,
  input  logic                                  cpl_write,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  cpl_line,
  output logic                                  rsp_valid,
  output logic [ID_W-1:0]                       rsp_id,
  output logic [TIME_W-1:0]                     rsp_latency,
  output logic                                  rsp_atomic_ok,
  output logic                                  cpl_unmatched,
  output logic                                  deadlock
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int OCC_W  = $clog2(RD_ENT + WR_ENT + 1);
  localparam int RD_IW  = (RD_ENT > 1) ? $clog2(RD_ENT) : 1;
  localparam int WR_IW  = (WR_ENT > 1) ? $clog2(WR_ENT) : 1;
  localparam int SUM_W  = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam int WD_W   = $clog2(THRESH + 1);
  localparam logic [OCC_W-1:0]  CAP    = OCC_W'(MAX_OUT);
  localparam logic [TIME_W-1:0] AGE_MAX = TIME_W'(THRESH);
  localparam logic [WD_W-1:0]   WD_END = WD_W'(THRESH);

  logic [RD_ENT-1:0] rd_v;
  logic [LINE_W-1:0] rd_line [RD_ENT];
  logic [ID_W-1:0]   rd_id   [RD_ENT];
  logic [TIME_W-1:0] rd_t    [RD_ENT];
  logic [WR_ENT-1:0] wr_v;
  logic [LINE_W-1:0] wr_line [WR_ENT];
  logic [ID_W-1:0]   wr_id   [WR_ENT];
  logic [TIME_W-1:0] wr_t    [WR_ENT];
  logic [WR_ENT-1:0] wr_ard, wr_awr;

  logic [TIME_W-1:0] now_q;
  logic [ID_W-1:0]   id_q;
  logic [OCC_W-1:0]  occ_q, occ_nx;
  logic              res_v;
  logic [LINE_W-1:0] res_line;
  logic              wd_arm;
  logic [WD_W-1:0]   wd_cnt;
  logic              dl_q;

  wire [OFF_W-1:0]  req_o  = req_addr[OFF_W-1:0];
  wire [LINE_W-1:0] req_ln = req_addr[ADDR_W-1:OFF_W];
  wire to_wr   = (req_type == 3'd2) || (req_type == 3'd3) || (req_type == 3'd4);
  wire type_ok = req_type <= 3'd4;
  wire mode_ok = req_mode != 2'd3;
  wire [SUM_W-1:0] span = SUM_W'(req_o) + SUM_W'(req_len);
  wire len_ok  = (req_len != '0) && (span <= SUM_W'(LINE_BYTES));

  logic [RD_ENT-1:0] rd_hit, rd_m, rd_old;
  logic [WR_ENT-1:0] wr_hit, wr_m, wr_old;

  for (genvar i = 0; i < RD_ENT; i++) begin : g_rd
    assign rd_hit[i] = rd_v[i] && (rd_line[i] == req_ln);
    assign rd_m[i]   = rd_v[i] && !cpl_write && (rd_line[i] == cpl_line);
    assign rd_old[i] = rd_v[i] && ((now_q - rd_t[i]) >= AGE_MAX);
  end
  for (genvar i = 0; i < WR_ENT; i++) begin : g_wr
    assign wr_hit[i] = wr_v[i] && (wr_line[i] == req_ln);
    assign wr_m[i]   = wr_v[i] && cpl_write && (wr_line[i] == cpl_line);
    assign wr_old[i] = wr_v[i] && ((now_q - wr_t[i]) >= AGE_MAX);
  end

  logic [RD_IW-1:0] rd_free;
  logic [WR_IW-1:0] wr_free;
  logic             rd_full, wr_full;

  always_comb begin
    rd_free = '0;
    rd_full = 1'b1;
    for (int i = RD_ENT - 1; i >= 0; i--)
      if (!rd_v[i]) begin
        rd_free = RD_IW'(i);
        rd_full = 1'b0;
      end
    wr_free = '0;
    wr_full = 1'b1;
    for (int i = WR_ENT - 1; i >= 0; i--)
      if (!wr_v[i]) begin
        wr_free = WR_IW'(i);
        wr_full = 1'b0;
      end
  end

  wire busy = (|rd_hit) || (|wr_hit);
  wire room = to_wr ? !wr_full : !rd_full;
  assign req_ready = type_ok && mode_ok && len_ok && !busy && room && (occ_q < CAP);
  wire accept = req_valid && req_ready;

  assign req_id    = id_q;
  assign iss_valid = accept;
  assign iss_line  = req_ln;
  assign iss_off   = req_o;
  assign iss_len   = req_len;
  assign iss_super = req_mode == 2'd1;
  always_comb begin
    case (req_type)
      3'd0:    iss_cmd = 2'd0;
      3'd1:    iss_cmd = 2'd1;
      3'd2:    iss_cmd = 2'd2;
      default: iss_cmd = 2'd3;
    endcase
  end

  logic [ID_W-1:0]   sel_id;
  logic [TIME_W-1:0] sel_t;
  logic              sel_ard, sel_awr;

  always_comb begin
    sel_id  = '0;
    sel_t   = '0;
    sel_ard = 1'b0;
    sel_awr = 1'b0;
    for (int i = 0; i < RD_ENT; i++)
      if (rd_m[i]) begin
        sel_id = rd_id[i];
        sel_t  = rd_t[i];
      end
    for (int i = 0; i < WR_ENT; i++)
      if (wr_m[i]) begin
        sel_id  = wr_id[i];
        sel_t   = wr_t[i];
        sel_ard = wr_ard[i];
        sel_awr = wr_awr[i];
      end
  end

  wire matched = (|rd_m) || (|wr_m);
  wire retire  = cpl_valid && matched;
  wire res_hit = res_v && (res_line == cpl_line);

  assign rsp_valid     = retire;
  assign rsp_id        = sel_id;
  assign rsp_latency   = now_q - sel_t;
  assign rsp_atomic_ok = retire && sel_awr && res_hit;
  assign cpl_unmatched = cpl_valid && !matched;
  assign deadlock      = dl_q;

  assign occ_nx = occ_q + OCC_W'(accept) - OCC_W'(retire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v   <= '0;
      wr_v   <= '0;
      wr_ard <= '0;
      wr_awr <= '0;
      for (int i = 0; i < RD_ENT; i++) begin
        rd_line[i] <= '0;
        rd_id[i]   <= '0;
        rd_t[i]    <= '0;
      end
      for (int i = 0; i < WR_ENT; i++) begin
        wr_line[i] <= '0;
        wr_id[i]   <= '0;
        wr_t[i]    <= '0;
      end
      now_q    <= '0;
      id_q     <= '0;
      occ_q    <= '0;
      res_v    <= 1'b0;
      res_line <= '0;
      wd_arm   <= 1'b0;
      wd_cnt   <= '0;
      dl_q     <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      occ_q <= occ_nx;

      if (retire) begin
        rd_v <= rd_v & ~rd_m;
        wr_v <= wr_v & ~wr_m;
        if (sel_ard) begin
          res_v    <= 1'b1;
          res_line <= cpl_line;
        end else if (sel_awr && res_hit) begin
          res_v <= 1'b0;
        end
      end

      if (accept) begin
        id_q <= id_q + 1'b1;
        if (to_wr) begin
          wr_v[wr_free]    <= 1'b1;
          wr_line[wr_free] <= req_ln;
          wr_id[wr_free]   <= id_q;
          wr_t[wr_free]    <= now_q;
          wr_ard[wr_free]  <= req_type == 3'd3;
          wr_awr[wr_free]  <= req_type == 3'd4;
        end else begin
          rd_v[rd_free]    <= 1'b1;
          rd_line[rd_free] <= req_ln;
          rd_id[rd_free]   <= id_q;
          rd_t[rd_free]    <= now_q;
        end
      end

      if (!wd_arm) begin
        if (accept) begin
          wd_arm <= 1'b1;
          wd_cnt <= WD_W'(1);
        end
      end else if (wd_cnt == WD_END) begin
        if ((|rd_old) || (|wr_old)) dl_q <= 1'b1;
        if (occ_nx != '0) wd_cnt <= WD_W'(1);
        else              wd_arm <= 1'b0;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/req_tracker_chk.sv
module req_tracker_chk #(
  parameter int RD_ENT  = 4,
  parameter int WR_ENT  = 4,
  parameter int MAX_OUT = 6,
  parameter int ID_W    = 8,
  parameter int OCC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ID_W-1:0]   req_id,
  input logic              rsp_valid,
  input logic              cpl_unmatched,
  input logic              deadlock,
  input logic [OCC_W-1:0]  occ,
  input logic [RD_ENT-1:0] rd_v,
  input logic [WR_ENT-1:0] wr_v,
  input logic [RD_ENT-1:0] rd_m,
  input logic [WR_ENT-1:0] wr_m
);
  p_occ_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ) == ($countones(rd_v) + $countones(wr_v)));

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ) <= MAX_OUT);

  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_m, wr_m}));

  p_id_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (req_id == ID_W'($past(req_id) + 1'b1)));

  p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(req_id));

  p_no_occ_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !rsp_valid) |=> $stable(occ));

  p_rsp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && cpl_unmatched));

  p_dl_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
endmodule

bind req_tracker req_tracker_chk #(
  .RD_ENT(RD_ENT), .WR_ENT(WR_ENT), .MAX_OUT(MAX_OUT), .ID_W(ID_W), .OCC_W(OCC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_id(req_id), .rsp_valid(rsp_valid), .cpl_unmatched(cpl_unmatched),
  .deadlock(deadlock), .occ(occ_q), .rd_v(rd_v), .wr_v(wr_v),
  .rd_m(rd_m), .wr_m(wr_m)
);

// File: tb/req_tracker_tb.sv
`timescale 1ns/1ps
module req_tracker_tb_top;
  localparam int THRESH = 64;
  localparam logic [2:0] LD = 3'd0, IF = 3'd1, ST = 3'd2, AR = 3'd3, AW = 3'd4;
  localparam logic [1:0] USR = 2'd0, SUP = 2'd1, DEV = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_type = '0;
  logic [15:0] req_addr = '0;
  logic [4:0] req_len = '0;
  logic [1:0] req_mode = '0;
  logic cpl_valid = 1'b0, cpl_write = 1'b0;
  logic [11:0] cpl_line = '0;
  logic req_ready, iss_valid, iss_super, rsp_valid, rsp_atomic_ok, cpl_unmatched, deadlock;
  logic [7:0] req_id, rsp_id;
  logic [1:0] iss_cmd;
  logic [11:0] iss_line;
  logic [3:0] iss_off;
  logic [4:0] iss_len;
  logic [15:0] rsp_latency;

  req_tracker #(.THRESH(THRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode),
    .req_ready(req_ready), .req_id(req_id), .iss_valid(iss_valid),
    .iss_cmd(iss_cmd), .iss_line(iss_line), .iss_off(iss_off), .iss_len(iss_len),
    .iss_super(iss_super), .cpl_valid(cpl_valid), .cpl_write(cpl_write),
    .cpl_line(cpl_line), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_latency(rsp_latency), .rsp_atomic_ok(rsp_atomic_ok),
    .cpl_unmatched(cpl_unmatched), .deadlock(deadlock)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic r_rdy, r_iv, r_sup;
  logic [7:0] r_id;
  logic [1:0] r_cmd;
  logic [11:0] r_line;
  longint r_cyc;
  logic c_v, c_ok, c_un;
  logic [7:0] c_id;
  logic [15:0] c_lat;
  longint c_cyc;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic send(input logic [2:0] t, input logic [15:0] a, input logic [4:0] l,
                      input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_len = l; req_mode = m;
    #1;
    r_rdy = req_ready; r_iv = iss_valid; r_id = req_id; r_cmd = iss_cmd;
    r_line = iss_line; r_sup = iss_super; r_cyc = cyc;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic cpl(input logic w, input logic [11:0] ln);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_write = w; cpl_line = ln;
    #1;
    c_v = rsp_valid; c_ok = rsp_atomic_ok; c_un = cpl_unmatched;
    c_id = rsp_id; c_lat = rsp_latency; c_cyc = cyc;
    @(posedge clk);
    #1 cpl_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R6 id after reset", req_id, 0);
    chk("R11 deadlock after reset", deadlock, 0);
    chk("R9 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_route();
    longint c0, c1, c2;
    do_reset();
    send(LD, 16'h0104, 5'd4, USR);
    chk("R1 load accepted", r_rdy, 1);
    chk("R6 first id", r_id, 0);
    chk("R7 load cmd", r_cmd, 0);
    chk("R7 load line", r_line, 12'h010);
    chk("R7 user mode", r_sup, 0);
    c0 = r_cyc;
    send(ST, 16'h0200, 5'd8, DEV);
    chk("R6 second id", r_id, 1);
    chk("R7 store cmd", r_cmd, 2);
    chk("R7 device as user", r_sup, 0);
    c1 = r_cyc;
    send(IF, 16'h0300, 5'd4, SUP);
    chk("R7 fetch cmd", r_cmd, 1);
    chk("R7 supervisor", r_sup, 1);
    c2 = r_cyc;
    repeat (3) @(posedge clk);
    cpl(1'b0, 12'h020);
    chk("R1 store line not in read table", c_un, 1);
    chk("R9 no rsp on unmatched", c_v, 0);
    cpl(1'b1, 12'h010);
    chk("R1 load line not in write table", c_un, 1);
    cpl(1'b1, 12'h020);
    chk("R8 store rsp valid", c_v, 1);
    chk("R8 store id", c_id, 1);
    chk("R8 store latency", c_lat, c_cyc - c1);
    cpl(1'b0, 12'h010);
    chk("R8 load id", c_id, 0);
    chk("R8 load latency", c_lat, c_cyc - c0);
    cpl(1'b0, 12'h030);
    chk("R8 fetch id", c_id, 2);
    chk("R8 fetch latency", c_lat, c_cyc - c2);
    send(LD, 16'h0104, 5'd4, USR);
    chk("R8 freed line reusable", r_rdy, 1);
    chk("R6 id continues", r_id, 3);
  endtask

  task automatic t_busy();
    do_reset();
    send(LD, 16'h0400, 5'd4, USR);
    chk("R3 first on line", r_rdy, 1);
    send(ST, 16'h0408, 5'd4, USR);
    chk("R3 store same line refused", r_rdy, 0);
    chk("R5 no issue on refusal", r_iv, 0);
    send(IF, 16'h040C, 5'd4, USR);
    chk("R3 fetch same line refused", r_rdy, 0);
    send(AR, 16'h0400, 5'd4, USR);
    chk("R3 atomic same line refused", r_rdy, 0);
    send(LD, 16'h0410, 5'd4, USR);
    chk("R3 other line accepted", r_rdy, 1);
    chk("R6 refusals use no id", r_id, 1);
    cpl(1'b0, 12'h040);
    chk("R8 busy line retired", c_id, 0);
    send(ST, 16'h0408, 5'd4, USR);
    chk("R3 line free after retire", r_rdy, 1);
    chk("R6 id after retire", r_id, 2);
  endtask

  task automatic t_cap();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      send(LD, 16'h1000 + 16'(i * 16), 5'd4, USR);
      chk("R4 read fill", r_rdy, 1);
    end
    send(LD, 16'h1040, 5'd4, USR);
    chk("R4 read table full", r_rdy, 0);
    send(ST, 16'h2000, 5'd4, USR);
    chk("R4 write table still open", r_rdy, 1);
    send(ST, 16'h2010, 5'd4, USR);
    chk("R2 reach cap", r_rdy, 1);
    send(ST, 16'h2020, 5'd4, USR);
    chk("R2 cap refuses store", r_rdy, 0);
    cpl(1'b1, 12'h200);
    chk("R8 retire under cap", c_v, 1);
    send(ST, 16'h2020, 5'd4, USR);
    chk("R2 accepted after retire", r_rdy, 1);
    chk("R6 id at cap", r_id, 6);
  endtask

  task automatic t_illegal();
    do_reset();
    send(LD, 16'h300C, 5'd5, USR);
    chk("R5 overruns line", r_rdy, 0);
    send(LD, 16'h300C, 5'd0, USR);
    chk("R5 zero length", r_rdy, 0);
    send(3'd5, 16'h3000, 5'd4, USR);
    chk("R5 bad type", r_rdy, 0);
    send(LD, 16'h3000, 5'd4, 2'd3);
    chk("R5 bad mode", r_rdy, 0);
    chk("R5 bad mode no issue", r_iv, 0);
    send(LD, 16'h300C, 5'd4, USR);
    chk("R5 exact fit accepted", r_rdy, 1);
    chk("R5 no id consumed", r_id, 0);
    send(ST, 16'h3100, 5'd16, USR);
    chk("R5 full line accepted", r_rdy, 1);
  endtask

  task automatic t_atomic();
    do_reset();
    send(AW, 16'h5000, 5'd4, USR);
    chk("R7 atomic write cmd", r_cmd, 3);
    cpl(1'b1, 12'h500);
    chk("R10 write without reservation", c_ok, 0);
    send(AR, 16'h6000, 5'd4, USR);
    chk("R7 atomic read cmd", r_cmd, 3);
    cpl(1'b1, 12'h600);
    chk("R10 read completion not ok", c_ok, 0);
    send(AW, 16'h6004, 5'd4, USR);
    cpl(1'b1, 12'h600);
    chk("R10 held reservation succeeds", c_ok, 1);
    send(AW, 16'h6000, 5'd4, USR);
    cpl(1'b1, 12'h600);
    chk("R10 reservation cleared", c_ok, 0);
    send(AR, 16'h7000, 5'd4, USR);
    cpl(1'b1, 12'h700);
    send(AR, 16'h8000, 5'd4, USR);
    cpl(1'b1, 12'h800);
    send(AW, 16'h7000, 5'd4, USR);
    cpl(1'b1, 12'h700);
    chk("R10 reservation moved away", c_ok, 0);
    send(ST, 16'h8000, 5'd4, USR);
    cpl(1'b1, 12'h800);
    chk("R10 store reports no atomic", c_ok, 0);
    send(AW, 16'h8000, 5'd4, USR);
    cpl(1'b1, 12'h800);
    chk("R10 store kept reservation", c_ok, 1);
  endtask

  task automatic t_watchdog();
    do_reset();
    send(LD, 16'h9000, 5'd4, USR);
    repeat (10) @(posedge clk);
    cpl(1'b0, 12'h900);
    repeat (3 * THRESH) @(posedge clk);
    #1 chk("R12 retired in time, idle gap", deadlock, 0);
    send(LD, 16'h9100, 5'd4, USR);
    repeat (THRESH - 2) @(posedge clk);
    #1 chk("R11 below threshold", deadlock, 0);
    repeat (5) @(posedge clk);
    #1 chk("R11 aged request flagged", deadlock, 1);
    cpl(1'b0, 12'h910);
    repeat (3) @(posedge clk);
    #1 chk("R11 flag sticky", deadlock, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_route();
        t_busy();
        t_cap();
        t_illegal();
        t_atomic();
        t_watchdog();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule